// File: doc/BRIEF.md
# Warm Restart Sequencer

This block controls a soft (warm) restart of a processor core. A rising edge on the soft-restart request arms a pending restart. In write-back mode the block holds the restart until the core reports an instruction boundary. Outside that mode it starts at the next clock. While the restart is pending, a hard reset cancels it. A cache flush defers it until the flush is reported complete.

Once started, the sequence walks a fixed number of steps. During that time it drives a selective clear mask over the core's state groups. Groups that a warm restart must keep are never cleared. The sequence ends with a one-cycle load of the restart fetch address. Releasing the request early has no effect on a sequence that has started.

Snoops stay live throughout. A snoop that hits a modified line starts a write-back and raises the address strobe for one cycle. The step counter then waits until the write-back is reported done.

Top module: `warm_reset_seq`

## Requirements
- R1: After `hard_rst` is sampled high, `busy`, `fetch_load`, `addr_strobe`, `clear_mask` and `fetch_addr` are all zero.
- R2: A 0-to-1 change of `soft_rst_req` sampled while the block is idle arms a pending restart. With `wb_mode`=1, `busy` rises the cycle after the first clock edge at which `insn_boundary` is high while the restart is pending. A boundary seen at the same edge as the arming edge does not count.
- R3: With `wb_mode`=0, a pending restart starts at the next clock edge after arming, with no boundary needed.
- R4: `flush_req` high at the same edge as a pending boundary wins. The restart then waits for `flush_done`, and a boundary seen together with `flush_done` does not count. It starts at the first boundary sampled after that.
- R5: `hard_rst` aborts a running sequence at once and discards a pending restart, so later boundaries start nothing.
- R6: With no snoop activity, `busy` stays high for exactly STEPS+1 cycles whatever `soft_rst_req` does. `fetch_load` is high only in the last of these cycles. During that cycle `fetch_addr` equals RESTART_ADDR (default 0xFFFFFFF0); at all other times it is zero.
- R7: `clear_mask` bit map: 0 general registers, 1 segment registers, 2 flags and instruction pointer, 3 other control bits, 4 debug registers, 5 translation buffer, 6 caches, 7 cache-disable/no-write control bits, 8 write buffers, 9 system-management base, 10 floating-point registers. While `busy` it equals 0x03F; otherwise it is zero.
- R8: When no write-back is outstanding, `snoop_hitm` is accepted. `addr_strobe` is then high for exactly the next cycle, in any state, including a running sequence with `soft_rst_req` still high. A `snoop_hitm` seen while a write-back is outstanding is ignored.
- R9: The step count holds at every edge from the accepting edge through the edge that samples `wb_done`. `busy` is lengthened by that number of cycles.
- R10: A rising edge of `soft_rst_req` while a restart is pending or running arms nothing further. A request held high after completion does not start a second sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous hard reset, active high |
| wb_mode | input | 1 | Cache in write-back mode: restart waits for an instruction boundary |
| soft_rst_req | input | 1 | Soft-restart request, edge armed |
| flush_req | input | 1 | Cache flush begins |
| flush_done | input | 1 | Cache flush completed |
| insn_boundary | input | 1 | Core is at an instruction boundary |
| snoop_hitm | input | 1 | Snoop hit a modified line |
| wb_done | input | 1 | Snoop write-back finished |
| busy | output | 1 | Sequence running |
| clear_mask | output | 11 | Per state group clear enable |
| addr_strobe | output | 1 | Address strobe for a snoop write-back |
| fetch_load | output | 1 | Load restart address into fetch |
| fetch_addr | output | ADDR_W | Restart address, valid with fetch_load |

## Verification
The bench builds the block with STEPS=5 and the default 32-bit restart address. The short sequence allows many complete runs in a brief test. With it, the exact busy length, the position of the load cycle and the lengthening caused by a snoop write-back can be counted against STEPS+1. Overlaps are also placed within reach: a flush and a boundary in the same cycle, a hard reset mid-run, and repeated snoop hits while a write-back is outstanding.

// File: rtl/warm_reset_pkg.sv
package warm_reset_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_FLUSH,
        ST_RUN,
        ST_LOAD
    } wr_state_e;

    localparam int GRP_N      = 11;
    localparam int GRP_GPR    = 0;
    localparam int GRP_SEG    = 1;
    localparam int GRP_FLAGIP = 2;
    localparam int GRP_CTRL   = 3;
    localparam int GRP_DBG    = 4;
    localparam int GRP_TLB    = 5;
    localparam int GRP_CACHE  = 6;
    localparam int GRP_CDNW   = 7;
    localparam int GRP_WBUF   = 8;
    localparam int GRP_SMBASE = 9;
    localparam int GRP_FPU    = 10;

    // Groups that survive a warm restart
    function automatic logic [GRP_N-1:0] keep_groups();
        logic [GRP_N-1:0] k;
        k = '0;
        k[GRP_CACHE]  = 1'b1;
        k[GRP_CDNW]   = 1'b1;
        k[GRP_WBUF]   = 1'b1;
        k[GRP_SMBASE] = 1'b1;
        k[GRP_FPU]    = 1'b1;
        return k;
    endfunction

    typedef struct packed {
        wr_state_e st;
        logic      req_prev;
    } wr_fsm_t;

    typedef struct packed {
        logic pend;
        logic strobe;
    } wr_snoop_t;

endpackage

// File: rtl/wr_snoop_track.sv
module wr_snoop_track (
    input  logic clk,
    input  logic hard_rst,
    input  logic snoop_hitm,
    input  logic wb_done,
    output logic addr_strobe,
    output logic hold
);
    import warm_reset_pkg::*;

    wr_snoop_t s_d, s_q;
    logic      accept;

    always_comb begin
        s_d      = s_q;
        accept   = snoop_hitm && !s_q.pend;
        s_d.strobe = accept;
        if (accept)
            s_d.pend = 1'b1;
        else if (s_q.pend && wb_done)
            s_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (hard_rst)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign addr_strobe = s_q.strobe;
    assign hold        = accept || s_q.pend;

    // strobe never lasts two cycles for one write-back
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (hard_rst)
        s_q.strobe |=> !s_q.strobe);

    // outstanding write-back only ends on wb_done
    assert_wb_waits_done_R9: assert property (@(posedge clk) disable iff (hard_rst)
        (s_q.pend && !wb_done) |=> s_q.pend);

endmodule

// File: rtl/wr_step_ctr.sv
module wr_step_ctr #(
    parameter int STEPS = 8
) (
    input  logic clk,
    input  logic hard_rst,
    input  logic clr,
    input  logic run,
    input  logic hold,
    output logic last
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(STEPS - 1);

    logic [CW-1:0] step_d, step_q;

    always_comb begin
        step_d = step_q;
        if (clr)
            step_d = '0;
        else if (run && !hold && (step_q != LAST_STEP))
            step_d = step_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (hard_rst)
            step_q <= '0;
        else
            step_q <= step_d;
    end

    assign last = (step_q == LAST_STEP);

    // counter frozen while a write-back holds the sequence
    assert_hold_freezes_R9: assert property (@(posedge clk) disable iff (hard_rst)
        (run && hold && !clr) |=> $stable(step_q));

endmodule

// File: rtl/wr_fsm.sv
module wr_fsm (
    input  logic clk,
    input  logic hard_rst,
    input  logic wb_mode,
    input  logic soft_rst_req,
    input  logic flush_req,
    input  logic flush_done,
    input  logic insn_boundary,
    input  logic hold,
    input  logic step_last,
    output warm_reset_pkg::wr_state_e state,
    output logic start
);
    import warm_reset_pkg::*;

    wr_fsm_t f_d, f_q;

    always_comb begin
        f_d          = f_q;
        f_d.req_prev = soft_rst_req;
        start        = 1'b0;
        case (f_q.st)
            ST_IDLE: begin
                if (soft_rst_req && !f_q.req_prev)
                    f_d.st = ST_ARMED;
            end
            ST_ARMED: begin
                if (flush_req)
                    f_d.st = ST_FLUSH;
                else if (!wb_mode || insn_boundary) begin
                    f_d.st = ST_RUN;
                    start  = 1'b1;
                end
            end
            ST_FLUSH: begin
                if (flush_done)
                    f_d.st = ST_ARMED;
            end
            ST_RUN: begin
                if (!hold && step_last)
                    f_d.st = ST_LOAD;
            end
            ST_LOAD:  f_d.st = ST_IDLE;
            default:  f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (hard_rst) begin
            f_q.st       <= ST_IDLE;
            f_q.req_prev <= soft_rst_req;
        end else begin
            f_q <= f_d;
        end
    end

    assign state = f_q.st;

    // a flush in progress blocks the start
    assert_flush_blocks_R4: assert property (@(posedge clk) disable iff (hard_rst)
        (f_q.st == ST_FLUSH && !flush_done) |=> (f_q.st == ST_FLUSH));

    // a running sequence is never abandoned except by hard reset
    assert_run_completes_R6: assert property (@(posedge clk) disable iff (hard_rst)
        (f_q.st == ST_RUN) |=> (f_q.st == ST_RUN || f_q.st == ST_LOAD));

endmodule

// File: rtl/warm_reset_seq.sv
module warm_reset_seq #(
    parameter int STEPS  = 8,
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] RESTART_ADDR = {{(ADDR_W-4){1'b1}}, 4'h0}
) (
    input  logic                                  clk,
    input  logic                                  hard_rst,
    input  logic                                  wb_mode,
    input  logic                                  soft_rst_req,
    input  logic                                  flush_req,
    input  logic                                  flush_done,
    input  logic                                  insn_boundary,
    input  logic                                  snoop_hitm,
    input  logic                                  wb_done,
    output logic                                  busy,
    output logic [warm_reset_pkg::GRP_N-1:0]      clear_mask,
    output logic                                  addr_strobe,
    output logic                                  fetch_load,
    output logic [ADDR_W-1:0]                     fetch_addr
);
    import warm_reset_pkg::*;

    localparam logic [GRP_N-1:0] KEEP = keep_groups();

    wr_state_e st;
    logic      start;
    logic      hold;
    logic      step_last;

    wr_snoop_track u_snoop (
        .clk         (clk),
        .hard_rst    (hard_rst),
        .snoop_hitm  (snoop_hitm),
        .wb_done     (wb_done),
        .addr_strobe (addr_strobe),
        .hold        (hold)
    );

    wr_fsm u_fsm (
        .clk           (clk),
        .hard_rst      (hard_rst),
        .wb_mode       (wb_mode),
        .soft_rst_req  (soft_rst_req),
        .flush_req     (flush_req),
        .flush_done    (flush_done),
        .insn_boundary (insn_boundary),
        .hold          (hold),
        .step_last     (step_last),
        .state         (st),
        .start         (start)
    );

    wr_step_ctr #(.STEPS(STEPS)) u_steps (
        .clk      (clk),
        .hard_rst (hard_rst),
        .clr      (start),
        .run      (st == ST_RUN),
        .hold     (hold),
        .last     (step_last)
    );

    assign busy       = (st == ST_RUN) || (st == ST_LOAD);
    assign fetch_load = (st == ST_LOAD);
    assign fetch_addr = fetch_load ? RESTART_ADDR : '0;

    for (genvar g = 0; g < GRP_N; g++) begin : g_mask
        if (KEEP[g]) begin : g_keep
            assign clear_mask[g] = 1'b0;
        end else begin : g_clr
            assign clear_mask[g] = busy;
        end
    end

    // load is the final busy cycle
    assert_load_ends_busy_R6: assert property (@(posedge clk) disable iff (hard_rst)
        fetch_load |=> !busy);

    // a sequence only starts from a pending request
    assert_start_from_armed_R2: assert property (@(posedge clk) disable iff (hard_rst)
        $rose(busy) |-> $past(st == ST_ARMED));

endmodule

// File: tb/warm_reset_seq_test.sv
module warm_reset_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int STEPS_T    = 5;
    localparam logic [31:0] EXP_ADDR = 32'hFFFF_FFF0;

    logic        clk = 1'b0;
    logic        hard_rst = 1'b1;
    logic        wb_mode = 1'b1;
    logic        soft_rst_req = 1'b0;
    logic        flush_req = 1'b0;
    logic        flush_done = 1'b0;
    logic        insn_boundary = 1'b0;
    logic        snoop_hitm = 1'b0;
    logic        wb_done = 1'b0;
    logic        busy;
    logic [10:0] clear_mask;
    logic        addr_strobe;
    logic        fetch_load;
    logic [31:0] fetch_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    warm_reset_seq #(.STEPS(STEPS_T), .ADDR_W(32)) uut (
        .clk(clk), .hard_rst(hard_rst), .wb_mode(wb_mode),
        .soft_rst_req(soft_rst_req), .flush_req(flush_req),
        .flush_done(flush_done), .insn_boundary(insn_boundary),
        .snoop_hitm(snoop_hitm), .wb_done(wb_done), .busy(busy),
        .clear_mask(clear_mask), .addr_strobe(addr_strobe),
        .fetch_load(fetch_load), .fetch_addr(fetch_addr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // counts busy cycles from the current sample; records load position
    task automatic drain(output int len, output int load_pos, output logic [31:0] addr, output int bad);
        len = 0; load_pos = 0; addr = '0; bad = 0;
        while (busy && len < 200) begin
            len++;
            if (clear_mask !== 11'h03F) bad++;
            if (fetch_load) begin
                load_pos = len;
                addr = fetch_addr;
            end else if (fetch_addr !== '0) bad++;
            tick();
        end
    endtask

    task automatic t_reset();
        hard_rst = 1'b1;
        tick(); tick();
        chk("R1 busy", busy, 0);
        chk("R1 fetch_load", fetch_load, 0);
        chk("R1 clear_mask", clear_mask, 0);
        chk("R1 addr_strobe", addr_strobe, 0);
        chk("R1 fetch_addr", fetch_addr, 0);
        hard_rst = 1'b0;
        tick();
    endtask

    task automatic t_basic();
        int len, lp, bad;
        logic [31:0] a;
        wb_mode = 1'b1;
        soft_rst_req = 1'b1;
        insn_boundary = 1'b1;   // same edge as arming: must not count
        tick();
        chk("R2 no start at arming edge", busy, 0);
        insn_boundary = 1'b0;
        tick(); tick();
        chk("R2 waits for boundary", busy, 0);
        insn_boundary = 1'b1;
        tick();
        chk("R2 starts after boundary", busy, 1);
        chk("R7 mask while busy", clear_mask, 11'h03F);
        insn_boundary = 1'b0;
        drain(len, lp, a, bad);
        chk("R6 busy length", len, STEPS_T + 1);
        chk("R6 load in last cycle", lp, STEPS_T + 1);
        chk("R6 restart address", a, EXP_ADDR);
        chk("R6 R7 mask and address in other cycles", bad, 0);
        chk("R7 mask idle", clear_mask, 0);
        // request still held high
        repeat (5) tick();
        chk("R10 held request no second run", busy, 0);
        soft_rst_req = 1'b0;
        tick();
    endtask

    task automatic t_release_early();
        int len, lp, bad;
        logic [31:0] a;
        soft_rst_req = 1'b1;
        tick();
        soft_rst_req = 1'b0;
        insn_boundary = 1'b1;
        tick();
        insn_boundary = 1'b0;
        chk("R6 started", busy, 1);
        tick();
        soft_rst_req = 1'b1;    // new edge while running
        tick();
        soft_rst_req = 1'b0;
        drain(len, lp, a, bad);
        chk("R6 runs to completion after release", len, STEPS_T - 1);
        chk("R6 load last", lp, STEPS_T - 1);
        repeat (4) begin
            insn_boundary = 1'b1;
            tick();
        end
        insn_boundary = 1'b0;
        chk("R10 edge while busy ignored", busy, 0);
    endtask

    task automatic t_no_wbmode();
        int len, lp, bad;
        logic [31:0] a;
        wb_mode = 1'b0;
        soft_rst_req = 1'b1;
        tick();
        chk("R3 pending after arming", busy, 0);
        soft_rst_req = 1'b0;
        tick();
        chk("R3 starts without boundary", busy, 1);
        drain(len, lp, a, bad);
        chk("R3 full sequence", len, STEPS_T + 1);
        wb_mode = 1'b1;
    endtask

    task automatic t_flush();
        int len, lp, bad;
        logic [31:0] a;
        soft_rst_req = 1'b1;
        tick();
        soft_rst_req = 1'b0;
        flush_req = 1'b1;
        insn_boundary = 1'b1;
        tick();
        chk("R4 flush wins over boundary", busy, 0);
        flush_req = 1'b0;
        tick(); tick(); tick();
        chk("R4 waits during flush", busy, 0);
        flush_done = 1'b1;
        tick();
        chk("R4 boundary with flush_done not counted", busy, 0);
        flush_done = 1'b0;
        tick();
        chk("R4 starts at boundary after flush", busy, 1);
        insn_boundary = 1'b0;
        drain(len, lp, a, bad);
        chk("R4 sequence length", len, STEPS_T + 1);
    endtask

    task automatic t_hard_abort();
        soft_rst_req = 1'b1;
        tick();
        soft_rst_req = 1'b0;
        insn_boundary = 1'b1;
        tick();
        insn_boundary = 1'b0;
        tick();
        hard_rst = 1'b1;
        tick();
        chk("R5 abort running busy", busy, 0);
        chk("R5 abort running mask", clear_mask, 0);
        hard_rst = 1'b0;
        tick();
        soft_rst_req = 1'b1;
        tick();
        soft_rst_req = 1'b0;
        hard_rst = 1'b1;
        tick();
        hard_rst = 1'b0;
        insn_boundary = 1'b1;
        tick(); tick(); tick();
        chk("R5 pending discarded", busy, 0);
        insn_boundary = 1'b0;
        tick();
    endtask

    task automatic t_snoop();
        int len, lp, bad;
        logic [31:0] a;
        snoop_hitm = 1'b1;      // idle snoop
        tick();
        chk("R8 strobe when idle", addr_strobe, 1);
        snoop_hitm = 1'b0;
        wb_done = 1'b1;
        tick();
        chk("R8 strobe one cycle", addr_strobe, 0);
        wb_done = 1'b0;
        soft_rst_req = 1'b1;    // kept high through the run
        tick();
        insn_boundary = 1'b1;
        tick();
        insn_boundary = 1'b0;
        chk("R9 started", busy, 1);
        snoop_hitm = 1'b1;
        tick();                 // accepting edge (paused 1)
        chk("R8 strobe during run with request high", addr_strobe, 1);
        tick();                 // ignored hit (paused 2)
        chk("R8 second hit ignored", addr_strobe, 0);
        snoop_hitm = 1'b0;
        tick();                 // paused 3
        wb_done = 1'b1;
        tick();                 // done edge (paused 4)
        wb_done = 1'b0;
        drain(len, lp, a, bad);
        // total = 1 + 4 + (len-1) samples; expected STEPS+1+4
        chk("R9 busy extended by paused edges", len + 4, STEPS_T + 1 + 4);
        chk("R9 load last", lp, len);
        chk("R9 restart address", a, EXP_ADDR);
        soft_rst_req = 1'b0;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_basic();
        t_release_early();
        t_no_wbmode();
        t_flush();
        t_hard_abort();
        t_snoop();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule